// File: doc/BRIEF.md
# Byte-Instruction Program Sequencer

This block is the fetch and control-flow engine of a small processor whose instructions are single bytes and whose memory holds 32 locations. It keeps a 5-bit program counter, drives it out as the fetch address, and reads back the byte stored there in the same cycle. The top three bits of that byte are the opcode and the low five bits are the argument.

The sequencer handles the flow-control opcodes itself: the no-op, the halt (timed or permanent), the relative jump and the conditional branch. For a branch it compares the two 8-bit register values it is given. Every other opcode is handed on through an execute-enable output, with its opcode and argument fields. The counter then steps by one, unless the execute unit asks for an absolute jump in that same cycle. All address arithmetic wraps modulo 32.

Top module: `byteSequencer`

## Requirements
- R1: While reset is low, fetchAddr is 0 and both halted and busy are 0. This holds even if the block was halted before the reset.
- R2: Opcode 000 (instruction bits 7:5) is a no-op. In one cycle the counter advances by one, and 31 wraps to 0.
- R3: Opcode 001 with an argument of 0 raises halted from the next cycle on. From then until reset, fetchAddr stays at the address of that halt instruction and execEnable stays 0.
- R4: Opcode 001 with an argument n from 1 to 31 moves the counter to the next address. It then holds busy high for exactly n cycles, with fetchAddr stable. After that the instruction at that next address executes.
- R5: Opcode 010 with argument bit 4 clear jumps forward by argument bits 3:0, modulo 32.
- R6: Opcode 010 with argument bit 4 set jumps backward by argument bits 3:0, modulo 32, and wraps below 0.
- R7: Opcode 110 selects a condition with argument bits 4:3. Code 0 is reg0 == reg1, 1 is reg0 != reg1, 2 is reg0 > reg1 and 3 is reg0 < reg1, all compared unsigned. When the condition holds, the counter becomes counter + 2 + argument bits 2:0, modulo 32.
- R8: A branch whose condition is false advances the counter by one.
- R9: Opcodes 011, 100, 101 and 111 raise execEnable in their cycle and present bits 7:5 on execOpcode and bits 4:0 on execArg. Without an absolute jump, the counter then advances by one. No other opcode, and no halted or busy cycle, raises execEnable.
- R10: If absJumpValid is high in a cycle where execEnable is high, the counter loads absJumpTarget modulo 32. A target of 48 gives 16, and 255 gives 31.
- R11: absJumpValid has no effect when the cycle is a no-op, halt, jump or branch.
- R12: During busy or halted cycles, the instruction byte and absJumpValid do not change fetchAddr, and execEnable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 8 | Byte read from memory at fetchAddr |
| reg0 | input | 8 | Register 0, left operand of branch compares |
| reg1 | input | 8 | Register 1, right operand of branch compares |
| absJumpValid | input | 1 | Absolute jump request from the execute unit |
| absJumpTarget | input | 8 | Absolute jump target, reduced modulo 32 |
| fetchAddr | output | 5 | Program counter / fetch address |
| execEnable | output | 1 | Current byte belongs to the execute unit |
| execOpcode | output | 3 | Opcode field of the current byte |
| execArg | output | 5 | Argument field of the current byte |
| halted | output | 1 | Permanent halt in force |
| busy | output | 1 | Timed halt counting down |

## Verification
Jump programs take forward and backward steps of the full 15 and of smaller distances. They cross 31 into 0 and 0 into 29, which separates correct modulo-32 wrap from carry into a wider counter. Branches run with reg0 below reg1, reg0 above reg1 with its top bit set, and the two equal. These cases separate each of the four condition codes, the unsigned compare and the taken and not-taken paths. Halt programs pair a 3-cycle and a 1-cycle timed pause with a permanent stop while an absolute jump request is held high. Execute-path programs load the targets 48 and 255 next to an unarmed execute cycle.

// File: rtl/seqPkg.sv
package seqPkg;

  localparam int INSTR_W = 8;
  localparam int OP_W    = 3;
  localparam int ARG_W   = INSTR_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_HALT   = 3'd1,
    OP_JREL   = 3'd2,
    OP_MOVE   = 3'd3,
    OP_PORT   = 3'd4,
    OP_ALU    = 3'd5,
    OP_BRANCH = 3'd6,
    OP_BITS   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GT = 2'd2,
    CMP_LT = 2'd3
  } cond_e;

  // Strobes from control to datapath; all zero means hold
  typedef struct packed {
    logic stepOne;
    logic relFwd;
    logic relBack;
    logic branchSkip;
    logic loadAbs;
    logic loadTimer;
    logic decTimer;
  } seqStrobes_t;

endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobe,
  input  logic [ARG_W-1:0]  arg,
  input  logic [DATA_W-1:0] reg0,
  input  logic [DATA_W-1:0] reg1,
  input  logic [DATA_W-1:0] absTarget,
  output logic [ADDR_W-1:0] pc,
  output logic              condTrue,
  output logic              timerZero
);

  localparam int DIST_W  = ARG_W - 1;
  localparam int SKIP_W  = ARG_W - 2;
  localparam int TIMER_W = ARG_W;

  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pcNext;
  logic [ADDR_W-1:0]  relDist;
  logic [ADDR_W-1:0]  skipDist;
  logic [ADDR_W-1:0]  absAddr;
  logic [TIMER_W-1:0] timerQ;
  cond_e              condSel;

  assign relDist  = ADDR_W'(arg[DIST_W-1:0]);
  assign skipDist = ADDR_W'(arg[SKIP_W-1:0]);
  assign condSel  = cond_e'(arg[ARG_W-2 +: 2]);

  // Reduce absolute target modulo the memory depth (depth = 2**ADDR_W)
  generate
    if (DATA_W >= ADDR_W) begin : g_absTrunc
      assign absAddr = absTarget[ADDR_W-1:0];
    end else begin : g_absExtend
      assign absAddr = ADDR_W'(absTarget);
    end
  endgenerate

  // Unsigned comparator, reg0 on the left
  always_comb begin
    unique case (condSel)
      CMP_EQ:  condTrue = (reg0 == reg1);
      CMP_NE:  condTrue = (reg0 != reg1);
      CMP_GT:  condTrue = (reg0 >  reg1);
      default: condTrue = (reg0 <  reg1);
    endcase
  end

  always_comb begin
    pcNext = pcQ;
    if (strobe.stepOne)         pcNext = pcQ + ADDR_W'(1);
    else if (strobe.relFwd)     pcNext = pcQ + relDist;
    else if (strobe.relBack)    pcNext = pcQ - relDist;
    else if (strobe.branchSkip) pcNext = pcQ + ADDR_W'(2) + skipDist;
    else if (strobe.loadAbs)    pcNext = absAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else begin
      pcQ <= pcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.loadTimer) begin
      timerQ <= arg;
    end else if (strobe.decTimer) begin
      timerQ <= timerQ - TIMER_W'(1);
    end
  end

  assign pc        = pcQ;
  assign timerZero = (timerQ == '0);

endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  opcode_e          opcode,
  input  logic [ARG_W-1:0] arg,
  input  logic             condTrue,
  input  logic             timerZero,
  input  logic             absJumpValid,
  output seqStrobes_t      strobe,
  output logic             execEnable,
  output logic             halted,
  output logic             busy
);

  logic haltedQ;
  logic haltSet;
  logic running;

  assign running = !haltedQ && timerZero;

  always_comb begin
    strobe     = '0;
    execEnable = 1'b0;
    haltSet    = 1'b0;
    if (running) begin
      unique case (opcode)
        OP_NOP: strobe.stepOne = 1'b1;
        OP_HALT: begin
          if (arg == '0) begin
            haltSet = 1'b1;
          end else begin
            strobe.stepOne   = 1'b1;
            strobe.loadTimer = 1'b1;
          end
        end
        OP_JREL: begin
          if (arg[ARG_W-1]) strobe.relBack = 1'b1;
          else              strobe.relFwd  = 1'b1;
        end
        OP_BRANCH: begin
          if (condTrue) strobe.branchSkip = 1'b1;
          else          strobe.stepOne    = 1'b1;
        end
        default: begin
          execEnable = 1'b1;
          if (absJumpValid) strobe.loadAbs = 1'b1;
          else              strobe.stepOne = 1'b1;
        end
      endcase
    end else if (!haltedQ && !timerZero) begin
      strobe.decTimer = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltedQ <= 1'b0;
    end else if (haltSet) begin
      haltedQ <= 1'b1;
    end
  end

  assign halted = haltedQ;
  assign busy   = !haltedQ && !timerZero;

endmodule

// File: rtl/byteSequencer.sv
module byteSequencer
  import seqPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  reg0,
  input  logic [DATA_W-1:0]  reg1,
  input  logic               absJumpValid,
  input  logic [DATA_W-1:0]  absJumpTarget,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               execEnable,
  output logic [OP_W-1:0]    execOpcode,
  output logic [ARG_W-1:0]   execArg,
  output logic               halted,
  output logic               busy
);

  opcode_e          opcode;
  logic [ARG_W-1:0] arg;
  seqStrobes_t      strobe;
  logic             condTrue;
  logic             timerZero;

  assign opcode = opcode_e'(instr[INSTR_W-1 -: OP_W]);
  assign arg    = instr[ARG_W-1:0];

  seqControl u_control (
    .clk          (clk),
    .rstN         (rstN),
    .opcode       (opcode),
    .arg          (arg),
    .condTrue     (condTrue),
    .timerZero    (timerZero),
    .absJumpValid (absJumpValid),
    .strobe       (strobe),
    .execEnable   (execEnable),
    .halted       (halted),
    .busy         (busy)
  );

  seqDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .arg       (arg),
    .reg0      (reg0),
    .reg1      (reg1),
    .absTarget (absJumpTarget),
    .pc        (fetchAddr),
    .condTrue  (condTrue),
    .timerZero (timerZero)
  );

  assign execOpcode = instr[INSTR_W-1 -: OP_W];
  assign execArg    = arg;

endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import seqPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instr,
  input logic               absJumpValid,
  input logic [DATA_W-1:0]  absJumpTarget,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic               execEnable,
  input logic               halted,
  input logic               busy
);

  logic [ADDR_W-1:0] pcPlusOne;
  logic [ADDR_W-1:0] absLow;
  logic              isNop;

  assign pcPlusOne = fetchAddr + ADDR_W'(1);
  assign absLow    = ADDR_W'(absJumpTarget);
  assign isNop     = (instr[INSTR_W-1 -: OP_W] == 3'd0);

  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (fetchAddr == '0 && !halted && !busy));

  p_nop_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !busy && isNop) |=> (fetchAddr == $past(pcPlusOne)));

  p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(fetchAddr)));

  p_busy_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(fetchAddr));

  p_halt_modes_apart_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(halted && busy));

  p_abs_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (execEnable && absJumpValid) |=> (fetchAddr == $past(absLow)));

  p_idle_no_exec_r12: assert property (@(posedge clk) disable iff (!rstN)
    (halted || busy) |-> !execEnable);

endmodule

bind byteSequencer seqChecker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_seqChecker (
  .clk           (clk),
  .rstN          (rstN),
  .instr         (instr),
  .absJumpValid  (absJumpValid),
  .absJumpTarget (absJumpTarget),
  .fetchAddr     (fetchAddr),
  .execEnable    (execEnable),
  .halted        (halted),
  .busy          (busy)
);

// File: tb/byteSequencer_bench.sv
module byteSequencer_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] mem [32];
  logic [7:0] instr;
  logic [7:0] reg0 = 8'd0;
  logic [7:0] reg1 = 8'd0;
  logic       absJumpValid;
  logic [7:0] absJumpTarget;
  logic [4:0] fetchAddr;
  logic       execEnable;
  logic [2:0] execOpcode;
  logic [4:0] execArg;
  logic       halted;
  logic       busy;

  logic absAll = 1'b0;
  logic armExec = 1'b0;

  int vectors = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0] pc;
    logic       hlt;
    logic       bsy;
    logic       exe;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign instr = mem[fetchAddr];
  assign absJumpValid = absAll || (armExec && (fetchAddr == 5'd2 || fetchAddr == 5'd17));
  assign absJumpTarget = (armExec && fetchAddr == 5'd17) ? 8'd255 :
                         (armExec ? 8'd48 : 8'd20);

  byteSequencer u_byteSequencer (
    .clk           (clk),
    .rstN          (rstN),
    .instr         (instr),
    .reg0          (reg0),
    .reg1          (reg1),
    .absJumpValid  (absJumpValid),
    .absJumpTarget (absJumpTarget),
    .fetchAddr     (fetchAddr),
    .execEnable    (execEnable),
    .execOpcode    (execOpcode),
    .execArg       (execArg),
    .halted        (halted),
    .busy          (busy)
  );

  task automatic expect1(input logic [4:0] pc, input logic h, input logic b,
                         input logic e, input string tag);
    expItem_t it;
    it.pc = pc; it.hlt = h; it.bsy = b; it.exe = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    absAll = 1'b0;
    armExec = 1'b0;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
  endtask

  task automatic release_();
    @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(posedge clk);
  endtask

  // Monitor: compares one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        vectors++;
        if (fetchAddr !== it.pc || halted !== it.hlt || busy !== it.bsy ||
            execEnable !== it.exe) begin
          failures++;
          $display("FAIL %s: pc/halted/busy/exec = %0d/%b/%b/%b expected %0d/%b/%b/%b",
                   it.tag, fetchAddr, halted, busy, execEnable,
                   it.pc, it.hlt, it.bsy, it.exe);
        end else if (it.exe && {execOpcode, execArg} !== mem[it.pc]) begin
          failures++;
          $display("FAIL R9: exec fields %h expected %h",
                   {execOpcode, execArg}, mem[it.pc]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;

    // Forward jumps and wrap past 31, absolute request ignored (R11)
    holdReset();
    mem[0] = 8'h4F; mem[15] = 8'h4F; mem[30] = 8'h00; mem[31] = 8'h00;
    absAll = 1'b1;
    release_();
    expect1(5'd0,  0, 0, 0, "R1");
    expect1(5'd15, 0, 0, 0, "R5");
    expect1(5'd30, 0, 0, 0, "R5 R11");
    expect1(5'd31, 0, 0, 0, "R2");
    expect1(5'd0,  0, 0, 0, "R2 wrap");
    expect1(5'd15, 0, 0, 0, "R5");
    drain();

    // Backward jumps and wrap below 0
    holdReset();
    mem[0] = 8'h53; mem[29] = 8'h00; mem[30] = 8'h5F; mem[15] = 8'h40;
    release_();
    expect1(5'd0,  0, 0, 0, "R1");
    expect1(5'd29, 0, 0, 0, "R6 wrap");
    expect1(5'd30, 0, 0, 0, "R2");
    expect1(5'd15, 0, 0, 0, "R6");
    expect1(5'd15, 0, 0, 0, "R5 zero distance");
    drain();

    // Branches, reg0 < reg1
    holdReset();
    reg0 = 8'd5; reg1 = 8'd9;
    mem[0] = 8'hDF; mem[9] = 8'hC0; mem[10] = 8'hCB; mem[15] = 8'hD1;
    mem[16] = 8'hDF; mem[25] = 8'hDF; mem[2] = 8'h00;
    release_();
    expect1(5'd0,  0, 0, 0, "R1");
    expect1(5'd9,  0, 0, 0, "R7 lt");
    expect1(5'd10, 0, 0, 0, "R8 eq false");
    expect1(5'd15, 0, 0, 0, "R7 ne");
    expect1(5'd16, 0, 0, 0, "R8 gt false");
    expect1(5'd25, 0, 0, 0, "R7 lt");
    expect1(5'd2,  0, 0, 0, "R7 wrap");
    expect1(5'd3,  0, 0, 0, "R2");
    drain();

    // Branches, reg0 above reg1 with top bit set (unsigned)
    holdReset();
    reg0 = 8'd200; reg1 = 8'd9;
    mem[0] = 8'hD2; mem[4] = 8'hC0; mem[5] = 8'hDF;
    release_();
    expect1(5'd0, 0, 0, 0, "R1");
    expect1(5'd4, 0, 0, 0, "R7 gt unsigned");
    expect1(5'd5, 0, 0, 0, "R8 eq false");
    expect1(5'd6, 0, 0, 0, "R8 lt false unsigned");
    drain();

    // Branches, registers equal
    holdReset();
    reg0 = 8'd77; reg1 = 8'd77;
    mem[0] = 8'hC5; mem[7] = 8'hCB; mem[8] = 8'hD1; mem[9] = 8'hDF;
    release_();
    expect1(5'd0,  0, 0, 0, "R1");
    expect1(5'd7,  0, 0, 0, "R7 eq");
    expect1(5'd8,  0, 0, 0, "R8 ne false");
    expect1(5'd9,  0, 0, 0, "R8 gt false");
    expect1(5'd10, 0, 0, 0, "R8 lt false");
    drain();

    // Timed and permanent halt with absolute request held high
    holdReset();
    mem[0] = 8'h23; mem[1] = 8'h21; mem[2] = 8'h00; mem[3] = 8'h20;
    absAll = 1'b1;
    release_();
    expect1(5'd0, 0, 0, 0, "R1");
    expect1(5'd1, 0, 1, 0, "R4");
    expect1(5'd1, 0, 1, 0, "R4 R12");
    expect1(5'd1, 0, 1, 0, "R4 R12");
    expect1(5'd1, 0, 0, 0, "R4 end");
    expect1(5'd2, 0, 1, 0, "R4 one cycle");
    expect1(5'd2, 0, 0, 0, "R4 end");
    expect1(5'd3, 0, 0, 0, "R2");
    expect1(5'd3, 1, 0, 0, "R3");
    expect1(5'd3, 1, 0, 0, "R3 R12");
    expect1(5'd3, 1, 0, 0, "R3 R12");
    drain();

    // Execute opcodes and absolute jumps; reset clears the halt (R1)
    holdReset();
    mem[0] = 8'h60; mem[1] = 8'h81; mem[2] = 8'hA0; mem[16] = 8'hE5;
    mem[17] = 8'hA3; mem[31] = 8'h7F;
    armExec = 1'b1;
    release_();
    expect1(5'd0,  0, 0, 1, "R1 after halt");
    expect1(5'd1,  0, 0, 1, "R9");
    expect1(5'd2,  0, 0, 1, "R9");
    expect1(5'd16, 0, 0, 1, "R10 48");
    expect1(5'd17, 0, 0, 1, "R9");
    expect1(5'd31, 0, 0, 1, "R10 255");
    expect1(5'd0,  0, 0, 1, "R9 wrap");
    drain();

    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

endmodule